// File: doc/BRIEF.md
# Transmit Sync Distribution Controller

This block turns one trigger into single-cycle sync strobes for the five timing-sensitive stages of a transmit path: the input FIFO, the complex mixer phase, the clock divider phase, the QMC offset corrector and the QMC gain/phase corrector. The trigger comes from one of two places. It can be an asynchronous board pin, which first passes through a two-flop synchronizer. It can also be a control bit that is already in the clock domain, written through the serial register interface. The block acts on a rising edge of the selected source and ignores its level.

A two-level mask decides which stages a trigger reaches. While the global sync disable is clear, every edge syncs all five stages in the same cycle, and the per-stage disable flags have no effect. While the global disable is set, a stage receives the strobe only if its own disable flag is clear. Each strobe feeds the matching stage of both transmit channels at once.

The FIFO strobe has a companion load command. It carries the reset values for the write and read pointers, which are a fixed separation apart, taken modulo the FIFO depth.

Top module: `tx_sync_dist`

## Requirements
- R1: After synchronous reset, all five strobes and the FIFO load command are low.
- R2: With `src_sel_sw`=1, a 0-to-1 change on `sw_sync_bit` made before clock edge k produces a strobe that is visible after edge k.
- R3: With `src_sel_sw`=0, a 0-to-1 change on `sync_pin` made before clock edge k produces a strobe that is visible after edge k+2, because of the two synchronizer stages.
- R4: With `glob_dis`=0, a trigger asserts all five strobe bits (`sync_strb`=5'b11111) in the same cycle, whatever the value of `blk_dis`.
- R5: With `glob_dis`=1, a trigger asserts `sync_strb[i]` exactly when `blk_dis[i]`=0. Bit mapping for both buses: 0 FIFO, 1 mixer, 2 divider, 3 QMC offset, 4 QMC gain/phase.
- R6: Each strobe is exactly one cycle wide. A source held high produces one strobe only, and a falling edge produces none.
- R7: Edges on the source that is not selected produce no strobe.
- R8: `fifo_load` pulses together with `sync_strb[0]` and at no other time. While it is high, `wr_ptr_init` equals SEP mod DEPTH (4 with defaults) and `rd_ptr_init` equals 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_pin | input | 1 | Asynchronous external sync trigger |
| sw_sync_bit | input | 1 | Register-written sync trigger, already synchronous to clk |
| src_sel_sw | input | 1 | 1 selects sw_sync_bit, 0 selects sync_pin |
| glob_dis | input | 1 | 1 enables per-stage masking, 0 syncs every stage |
| blk_dis | input | 5 | Per-stage disable flags, used only while glob_dis=1 |
| sync_strb | output | 5 | One-cycle sync strobes, one bit per stage |
| fifo_load | output | 1 | FIFO pointer load command |
| wr_ptr_init | output | 3 | Write pointer reset value |
| rd_ptr_init | output | 3 | Read pointer reset value |

## Verification
If the edge-history register held a wrong value, a trigger would be missed or repeated. This shows on `sync_strb` in the first cycle after the trigger, as a missing pulse or a pulse that lasts two cycles. A synchronizer chain of the wrong length moves the pin-driven pulse off its expected cycle, so every check uses a fixed latency and accepts the pulse in no other cycle. A fault in the gating shows as a wrong bit pattern in the single strobe cycle. The global/per-stage masks are tested with several patterns to expose such faults.

// File: rtl/tx_sync_pkg.sv
// Shared constants and types for the transmit sync distribution block.
// Assumes five synced stages in the fixed bit order below.
package tx_sync_pkg;
    localparam int NUM_BLK = 5;
    localparam int BLK_FIFO = 0;
    localparam int BLK_MIX  = 1;
    localparam int BLK_DIV  = 2;
    localparam int BLK_QOFS = 3;
    localparam int BLK_QGP  = 4;
    typedef logic [NUM_BLK-1:0] blk_mask_t;
endpackage

// File: rtl/tx_sync_src.sv
// Source stage: brings the pin into the clock domain, selects the active
// source and detects its rising edge. Assumes sw_bit is already synchronous.
module tx_sync_src #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic sw_bit,
    input  logic sel_sw,
    output logic rise
);
    logic [SYNC_STAGES-1:0] chain_q;
    logic                   sel_src;
    logic                   prev_q;

    // Synchronizer chain for the asynchronous pin.
    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= pin;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[SYNC_STAGES-2:0], pin};
            end
        end
    endgenerate

    // Pick the active trigger source.
    always_comb sel_src = sel_sw ? sw_bit : chain_q[SYNC_STAGES-1];

    // Remember the last sampled source level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sel_src;
    end

    // Rising edge of the selected source.
    always_comb rise = sel_src & ~prev_q;
endmodule

// File: rtl/tx_sync_gate.sv
// Gating stage: turns an edge into registered one-cycle strobes, masked
// per stage only while the global disable is set.
module tx_sync_gate
    import tx_sync_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rise,
    input  logic      glob_dis,
    input  blk_mask_t blk_dis,
    output blk_mask_t strb
);
    genvar i;
    generate
        for (i = 0; i < NUM_BLK; i++) begin : g_blk
            // Register the strobe for stage i when it is allowed.
            always_ff @(posedge clk) begin
                if (!rst_n) strb[i] <= 1'b0;
                else        strb[i] <= rise & (~glob_dis | ~blk_dis[i]);
            end

            // R5: a masked stage never strobes while per-stage mode is on.
            a_r5_mask_respected: assert property (@(posedge clk) disable iff (!rst_n)
                strb[i] |-> !($past(glob_dis) && $past(blk_dis[i])));

            // R6: strobe never lasts two cycles.
            a_r6_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
                strb[i] |=> !strb[i]);
        end
    endgenerate
endmodule

// File: rtl/tx_fifo_ptr_init.sv
// FIFO pointer initializer: issues the load command with the write pointer
// placed SEP entries ahead of the read pointer, modulo DEPTH.
module tx_fifo_ptr_init #(
    parameter int DEPTH = 8,
    parameter int SEP   = 4,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_strb,
    output logic          load,
    output logic [PW-1:0] wr_ptr,
    output logic [PW-1:0] rd_ptr
);
    localparam int WR_INIT = SEP % DEPTH;

    // Load command follows the FIFO strobe; pointer values are fixed.
    always_comb begin
        load   = fifo_strb;
        rd_ptr = '0;
        wr_ptr = PW'(WR_INIT);
    end

    // R8: loaded pointers are separated by SEP modulo the depth.
    a_r8_separation: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (PW'(wr_ptr - rd_ptr) == PW'(WR_INIT)));
endmodule

// File: rtl/tx_sync_dist.sv
// Top: transmit sync distribution. One selected trigger fans out to five
// stage strobes shared by both channels, plus the FIFO pointer load.
module tx_sync_dist
    import tx_sync_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FIFO_DEPTH  = 8,
    parameter int FIFO_SEP    = 4,
    localparam int PW = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sync_pin,
    input  logic          sw_sync_bit,
    input  logic          src_sel_sw,
    input  logic          glob_dis,
    input  logic [4:0]    blk_dis,
    output logic [4:0]    sync_strb,
    output logic          fifo_load,
    output logic [PW-1:0] wr_ptr_init,
    output logic [PW-1:0] rd_ptr_init
);
    logic rise;

    tx_sync_src #(.SYNC_STAGES(SYNC_STAGES)) src_i (
        .clk(clk), .rst_n(rst_n), .pin(sync_pin), .sw_bit(sw_sync_bit),
        .sel_sw(src_sel_sw), .rise(rise)
    );

    tx_sync_gate gate_i (
        .clk(clk), .rst_n(rst_n), .rise(rise), .glob_dis(glob_dis),
        .blk_dis(blk_dis), .strb(sync_strb)
    );

    tx_fifo_ptr_init #(.DEPTH(FIFO_DEPTH), .SEP(FIFO_SEP)) ptr_i (
        .clk(clk), .rst_n(rst_n), .fifo_strb(sync_strb[BLK_FIFO]),
        .load(fifo_load), .wr_ptr(wr_ptr_init), .rd_ptr(rd_ptr_init)
    );

    // R4: in chip-wide mode any strobe reaches every stage.
    a_r4_all_together: assert property (@(posedge clk) disable iff (!rst_n)
        ((|sync_strb) && !$past(glob_dis)) |-> (&sync_strb));
endmodule

// File: tb/tx_sync_dist_tb_top.sv
module tx_sync_dist_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PIN_LAT = 3;
    localparam int SW_LAT  = 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_pin = 1'b0, sw_sync_bit = 1'b0, src_sel_sw = 1'b1, glob_dis = 1'b0;
    logic [4:0] blk_dis = '0;
    logic [4:0] sync_strb;
    logic       fifo_load;
    logic [2:0] wr_ptr_init, rd_ptr_init;
    int checks = 0, fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tx_sync_dist dut_i (
        .clk(clk), .rst_n(rst_n), .sync_pin(sync_pin), .sw_sync_bit(sw_sync_bit),
        .src_sel_sw(src_sel_sw), .glob_dis(glob_dis), .blk_dis(blk_dis),
        .sync_strb(sync_strb), .fifo_load(fifo_load),
        .wr_ptr_init(wr_ptr_init), .rd_ptr_init(rd_ptr_init)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Observe win cycles (sampled at negedge); expect exactly one strobe of
    // value exp at cycle lat, or none at all when exp is zero.
    task automatic watch(string req, int lat, logic [4:0] exp, int win);
        int hits = 0;
        for (int c = 1; c <= win; c++) begin
            @(posedge clk); @(negedge clk);
            if (sync_strb != 0 || fifo_load) begin
                hits++;
                check({req, " strobe cycle"}, c, lat);
                check({req, " strobe mask"}, sync_strb, exp);
                check({req, " R8 load with fifo strobe"}, fifo_load, exp[0]);
                if (fifo_load) begin
                    check({req, " R8 wr_ptr"}, wr_ptr_init, 3'd4);
                    check({req, " R8 rd_ptr"}, rd_ptr_init, 3'd0);
                end
            end
        end
        check({req, " pulse count"}, hits, (exp != 0) ? 1 : 0);
    endtask

    task automatic quiet();
        sync_pin = 1'b0; sw_sync_bit = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 strobes after reset", sync_strb, 5'd0);
        check("R1 load after reset", fifo_load, 1'b0);
    endtask

    task automatic t_sw_global();
        src_sel_sw = 1'b1; glob_dis = 1'b0; blk_dis = 5'b10101;
        sw_sync_bit = 1'b1;
        watch("R2 R4 sw global", SW_LAT, 5'b11111, 6);
        quiet();
    endtask

    task automatic t_pin_global();
        src_sel_sw = 1'b0; glob_dis = 1'b0; blk_dis = 5'b11111;
        repeat (3) @(negedge clk);
        sync_pin = 1'b1;
        watch("R3 R4 pin global", PIN_LAT, 5'b11111, 8);
        quiet();
    endtask

    task automatic t_block();
        src_sel_sw = 1'b1; glob_dis = 1'b1;
        blk_dis = 5'b01010; sw_sync_bit = 1'b1;
        watch("R5 mask 01010", SW_LAT, 5'b10101, 5);
        quiet();
        blk_dis = 5'b00001; sw_sync_bit = 1'b1;
        watch("R5 R8 fifo masked", SW_LAT, 5'b11110, 5);
        quiet();
        blk_dis = 5'b11111; sw_sync_bit = 1'b1;
        watch("R5 all masked", SW_LAT, 5'b00000, 5);
        quiet();
        src_sel_sw = 1'b0; blk_dis = 5'b10000;
        repeat (3) @(negedge clk);
        sync_pin = 1'b1;
        watch("R5 pin mask 10000", PIN_LAT, 5'b01111, 6);
        quiet();
    endtask

    task automatic t_hold();
        src_sel_sw = 1'b1; glob_dis = 1'b0; blk_dis = '0;
        sw_sync_bit = 1'b1;
        watch("R6 held level", SW_LAT, 5'b11111, 12);
        sw_sync_bit = 1'b0;
        watch("R6 falling edge", 0, 5'b00000, 6);
    endtask

    task automatic t_ignore();
        src_sel_sw = 1'b1; glob_dis = 1'b0;
        sync_pin = 1'b1;
        watch("R7 pin ignored", 0, 5'b00000, 6);
        sync_pin = 1'b0;
        repeat (4) @(negedge clk);
        src_sel_sw = 1'b0;
        repeat (4) @(negedge clk);
        sw_sync_bit = 1'b1;
        watch("R7 sw ignored", 0, 5'b00000, 6);
        quiet();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_sw_global();
        t_pin_global();
        t_block();
        t_hold();
        t_ignore();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule